// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block holds a small array of transmit mailboxes and decides which one the bus engine sends next. Each mailbox has a control/status word (state code, three local priority bits, a 16-bit time stamp) and an identifier word. The CPU fills the mailboxes through a simple register port. Among the mailboxes marked ready, the arbiter picks a winner. It picks by lowest identifier, optionally with the local priority bits placed above the identifier, or simply by lowest mailbox index. The arbiter presents the winner to the bus engine, which commits it with a start strobe.

When the engine reports a successful frame, the block finishes the mailbox. It captures the free-running timer into the time stamp, marks the mailbox inactive, sets its interrupt flag and asserts the interrupt line if that flag is unmasked. With the abort feature on, software can cancel a mailbox that is not yet committed. A finished or aborted mailbox is then locked against CPU writes until its flag is cleared. With the abort feature off, software may deactivate a mailbox at any time. A frame that is already committed then completes silently.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset no mailbox is selected, tx_busy and irq are low, and all flags, masks, configuration bits and mailbox words read as zero.
- R2: With config bit0=0 and bit1=0, the selected mailbox is the ready one (state code 4'b1100 in CS bits [27:24]) with the lowest identifier, and the lower index wins a tie. The selection is visible one cycle after the state it depends on.
- R3: With config bit0=1, the selected mailbox is the ready one with the lowest index, whatever the identifiers.
- R4: With config bit0=0 and bit1=1, the ordering key is {CS bits [22:20], identifier}, and the lowest key wins.
- R5: A mailbox whose code is not 4'b1100 (in particular 4'b1000 or 4'b1001) never takes part in selection.
- R6: A CPU write to a mailbox's CS word excludes that mailbox from the selection made in the same cycle and blocks a start on it in that cycle.
- R7: tx_start while a mailbox is selected and tx_busy is low commits it. tx_busy then stays high and the selection outputs hold that mailbox until tx_done.
- R8: On tx_done for a committed mailbox whose code is still 4'b1100, the CS stamp takes the timer value, the code becomes 4'b1000, its flag is set, and irq rises if the mask bit is set.
- R9: With config bit2=1, writing code 4'b1001 to a ready mailbox that is not committed stores 4'b1001 and sets its flag. Writes to a committed mailbox are ignored, and its frame completes as in R8.
- R10: With config bit2=1, CS and ID writes to a mailbox whose flag is set are ignored until software clears the flag.
- R11: With config bit2=0, a mailbox rewritten to 4'b1000 while committed gets no stamp, no code change and no flag when tx_done arrives.
- R12: Writing 1 to a flag bit clears it. A completion or abort in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 5 | Bit4=1: global (0 config, 1 mask, 2 flags); else {index, word} with word 0=CS, 1=ID |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Combinational read data for cpu_addr |
| timer | input | 16 | Free-running time base |
| tx_start | input | 1 | Bus engine commits the selected mailbox |
| tx_done | input | 1 | Bus engine reports a successful frame |
| sel_valid | output | 1 | A mailbox is selected or committed |
| sel_idx | output | 3 | Index of that mailbox |
| sel_id | output | 11 | Identifier of that mailbox |
| tx_busy | output | 1 | A mailbox is committed |
| irq | output | 1 | OR of flags under the mask |

## Verification
A CPU access and a completion can land on the same edge. This is the central hazard. The bench sets this up twice. First, it writes a flag clear in the cycle that tx_done finishes a different mailbox whose flag is being cleared by that same write. The finishing flag must survive while the other flag clears. Second, with the abort feature off, it rewrites a committed mailbox to inactive before tx_done. A CS write racing a selection is also provoked, and the selection is read back on the very next cycle. Each outcome is judged by reading back the CS word, the flag register and the selection outputs.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int STAMP_W = 16;

  localparam logic [3:0] CODE_INACT = 4'b1000;
  localparam logic [3:0] CODE_ABORT = 4'b1001;
  localparam logic [3:0] CODE_SEND  = 4'b1100;

  typedef struct packed {
    logic [3:0]         code;
    logic [2:0]         lprio;
    logic [STAMP_W-1:0] stamp;
  } mb_cs_t;

  typedef struct packed {
    logic abort_en;
    logic lprio_en;
    logic by_index;
  } txmb_cfg_t;

  // ordering key: lower wins; index mode flattens all keys so index decides
  function automatic logic [31:0] prio_key(input logic [28:0] id,
                                           input logic [2:0] lprio,
                                           input txmb_cfg_t cfg);
    if (cfg.by_index) return '0;
    return {cfg.lprio_en ? lprio : 3'b000, id};
  endfunction

  function automatic mb_cs_t unpack_cs(input logic [31:0] w);
    mb_cs_t c;
    c.code  = w[27:24];
    c.lprio = w[22:20];
    c.stamp = w[STAMP_W-1:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_cs(input mb_cs_t c);
    return {4'b0000, c.code, 1'b0, c.lprio, 4'b0000, c.stamp};
  endfunction
endpackage

// File: rtl/txmb_store.sv
module txmb_store
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 11,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  txmb_cfg_t                    cfg,
  input  logic [NUM_MB-1:0]            wr_cs,
  input  logic [NUM_MB-1:0]            wr_id,
  input  logic [31:0]                  wdata,
  input  logic [NUM_MB-1:0]            flag,
  input  logic                         busy,
  input  logic [IDX_W-1:0]             flight_idx,
  input  logic                         tx_done,
  input  logic [STAMP_W-1:0]           timer,
  output mb_cs_t [NUM_MB-1:0]          cs_o,
  output logic [NUM_MB-1:0][ID_W-1:0]  id_o,
  output logic [NUM_MB-1:0]            done_vec,
  output logic [NUM_MB-1:0]            abort_vec
);
  mb_cs_t nxt_cs;
  assign nxt_cs = unpack_cs(wdata);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
    mb_cs_t          cs_q;
    logic [ID_W-1:0] id_q;
    logic hit, lock, take_cs, take_id, fin, abrt;

    assign hit     = busy && (flight_idx == IDX_W'(i));
    assign lock    = cfg.abort_en && (flag[i] || hit);
    assign take_cs = wr_cs[i] && !lock;
    assign take_id = wr_id[i] && !lock;
    assign fin     = tx_done && hit && (cs_q.code == CODE_SEND) && !take_cs;
    assign abrt    = take_cs && cfg.abort_en && (nxt_cs.code == CODE_ABORT)
                     && (cs_q.code == CODE_SEND);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cs_q <= '0;
        id_q <= '0;
      end else begin
        if (take_cs) begin
          cs_q <= nxt_cs;
        end else if (fin) begin
          cs_q.code  <= CODE_INACT;
          cs_q.stamp <= timer;
        end
        if (take_id) id_q <= wdata[ID_W-1:0];
      end
    end

    assign cs_o[i]      = cs_q;
    assign id_o[i]      = id_q;
    assign done_vec[i]  = fin;
    assign abort_vec[i] = abrt;
  end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
  parameter int NUM_MB = 8,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_MB-1:0][31:0]  key,
  input  logic [NUM_MB-1:0]        cand,
  input  logic [NUM_MB-1:0]        touch,
  input  logic                     tx_start,
  input  logic                     tx_done,
  output logic                     win_vld,
  output logic [IDX_W-1:0]         win_idx,
  output logic                     busy,
  output logic [IDX_W-1:0]         flight_idx,
  output logic                     start_ok
);
  logic [NUM_MB-1:0] flight_oh, elig;
  logic              best_vld;
  logic [IDX_W-1:0]  best_idx;
  logic [31:0]       best_key;

  always_comb begin
    flight_oh = '0;
    if (busy) flight_oh[flight_idx] = 1'b1;
  end

  assign elig = cand & ~touch & ~flight_oh;

  // descending scan with <= so the lowest index wins equal keys
  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    best_key = '1;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (elig[i] && (key[i] <= best_key)) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
        best_key = key[i];
      end
    end
  end

  assign start_ok = tx_start && !busy && win_vld && elig[win_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_vld    <= 1'b0;
      win_idx    <= '0;
      busy       <= 1'b0;
      flight_idx <= '0;
    end else begin
      win_vld <= best_vld;
      win_idx <= best_idx;
      if (start_ok) begin
        busy       <= 1'b1;
        flight_idx <= win_idx;
      end else if (tx_done && busy) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txmb_irq.sv
module txmb_irq #(
  parameter int NUM_MB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_MB-1:0] set_vec,
  input  logic              clr_wr,
  input  logic              mask_wr,
  input  logic [NUM_MB-1:0] wdata,
  output logic [NUM_MB-1:0] flag,
  output logic [NUM_MB-1:0] mask,
  output logic              irq
);
  logic [NUM_MB-1:0] clr_vec;
  assign clr_vec = clr_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      mask <= '0;
    end else begin
      flag <= (flag & ~clr_vec) | set_vec;
      if (mask_wr) mask <= wdata;
    end
  end

  assign irq = |(flag & mask);
endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 11,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [31:0]        cpu_wdata,
  output logic [31:0]        cpu_rdata,
  input  logic [STAMP_W-1:0] timer,
  input  logic               tx_start,
  input  logic               tx_done,
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_idx,
  output logic [ID_W-1:0]    sel_id,
  output logic               tx_busy,
  output logic               irq
);
  logic                        is_glob, is_id;
  logic [IDX_W-1:0]            mb_idx;
  logic [NUM_MB-1:0]           wr_cs, wr_id;
  logic                        cfg_wr, mask_wr, clr_wr;
  txmb_cfg_t                   cfg;
  mb_cs_t [NUM_MB-1:0]         cs;
  logic [NUM_MB-1:0][ID_W-1:0] id;
  logic [NUM_MB-1:0][31:0]     key;
  logic [NUM_MB-1:0]           cand, done_vec, abort_vec, set_vec, flag, mask;
  logic                        win_vld, start_ok;
  logic [IDX_W-1:0]            win_idx, flight_idx;

  assign is_glob = cpu_addr[ADDR_W-1];
  assign is_id   = cpu_addr[0];
  assign mb_idx  = cpu_addr[IDX_W:1];
  assign cfg_wr  = cpu_wr && is_glob && (cpu_addr[1:0] == 2'd0);
  assign mask_wr = cpu_wr && is_glob && (cpu_addr[1:0] == 2'd1);
  assign clr_wr  = cpu_wr && is_glob && (cpu_addr[1:0] == 2'd2);

  for (genvar i = 0; i < NUM_MB; i++) begin : g_dec
    assign wr_cs[i] = cpu_wr && !is_glob && !is_id && (mb_idx == IDX_W'(i));
    assign wr_id[i] = cpu_wr && !is_glob &&  is_id && (mb_idx == IDX_W'(i));
    assign cand[i]  = (cs[i].code == CODE_SEND);
    assign key[i]   = prio_key(29'(id[i]), cs[i].lprio, cfg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= txmb_cfg_t'(cpu_wdata[2:0]);
  end

  txmb_store #(.NUM_MB(NUM_MB), .ID_W(ID_W)) store_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .wr_cs(wr_cs), .wr_id(wr_id),
    .wdata(cpu_wdata), .flag(flag), .busy(tx_busy), .flight_idx(flight_idx),
    .tx_done(tx_done), .timer(timer), .cs_o(cs), .id_o(id),
    .done_vec(done_vec), .abort_vec(abort_vec)
  );

  txmb_arbiter #(.NUM_MB(NUM_MB)) arb_i (
    .clk(clk), .rst_n(rst_n), .key(key), .cand(cand), .touch(wr_cs),
    .tx_start(tx_start), .tx_done(tx_done), .win_vld(win_vld),
    .win_idx(win_idx), .busy(tx_busy), .flight_idx(flight_idx),
    .start_ok(start_ok)
  );

  assign set_vec = done_vec | abort_vec;

  txmb_irq #(.NUM_MB(NUM_MB)) irq_i (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_wr(clr_wr),
    .mask_wr(mask_wr), .wdata(cpu_wdata[NUM_MB-1:0]), .flag(flag),
    .mask(mask), .irq(irq)
  );

  assign sel_valid = tx_busy || win_vld;
  assign sel_idx   = tx_busy ? flight_idx : win_idx;
  assign sel_id    = id[sel_idx];

  always_comb begin
    cpu_rdata = '0;
    if (is_glob) begin
      case (cpu_addr[1:0])
        2'd0:    cpu_rdata[2:0]        = cfg;
        2'd1:    cpu_rdata[NUM_MB-1:0] = mask;
        2'd2:    cpu_rdata[NUM_MB-1:0] = flag;
        default: cpu_rdata = '0;
      endcase
    end else if (int'(mb_idx) < NUM_MB) begin
      if (is_id) cpu_rdata[ID_W-1:0] = id[mb_idx];
      else       cpu_rdata = pack_cs(cs[mb_idx]);
    end
  end
endmodule

// File: rtl/txmb_checker.sv
module txmb_checker #(
  parameter int NUM_MB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_done,
  input logic              tx_busy,
  input logic              start_ok,
  input logic [NUM_MB-1:0] done_vec,
  input logic [NUM_MB-1:0] set_vec,
  input logic [NUM_MB-1:0] flag
);
  assert_one_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

  assert_finish_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |-> tx_busy);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_done) |=> tx_busy);

  assert_start_commits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> tx_busy);

  assert_done_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_done) |=> !tx_busy);

  assert_flag_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & ~$past(set_vec)) == '0));
endmodule

bind can_txmb_arbiter txmb_checker #(.NUM_MB(NUM_MB)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_done(tx_done), .tx_busy(tx_busy),
  .start_ok(start_ok), .done_vec(done_vec), .set_vec(set_vec), .flag(flag)
);

// File: tb/can_txmb_arbiter_tb_top.sv
module can_txmb_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [15:0] timer = '0;
  logic        tx_start = 1'b0, tx_done = 1'b0;
  logic        sel_valid, tx_busy, irq;
  logic [2:0]  sel_idx;
  logic [10:0] sel_id;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_txmb_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .timer(timer),
    .tx_start(tx_start), .tx_done(tx_done), .sel_valid(sel_valid),
    .sel_idx(sel_idx), .sel_id(sel_id), .tx_busy(tx_busy), .irq(irq)
  );

  localparam int K_SEL = 0, K_RD = 1, K_BUSY = 2, K_IRQ = 3;
  localparam logic [4:0] A_CFG = 5'h10, A_MASK = 5'h11, A_FLAG = 5'h12;
  localparam logic [31:0] SEND = 32'h0C00_0000, INACT = 32'h0800_0000, ABRT = 32'h0900_0000;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  function automatic logic [4:0] cs_a(input int i); return 5'(i << 1); endfunction
  function automatic logic [4:0] id_a(input int i); return 5'((i << 1) | 1); endfunction
  function automatic logic [31:0] selx(input bit v, input int i);
    return v ? (32'h100 | 32'(i)) : 32'h0;
  endfunction

  // monitor: pops expected items and compares against the observed ports
  initial forever begin
    @(negedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_SEL:   act = selx(sel_valid, int'(sel_idx));
        K_RD:    act = cpu_rdata;
        K_BUSY:  act = 32'(tx_busy);
        default: act = 32'(irq);
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push_now(input int kind, input logic [31:0] exp, input string tag);
    #1; q.push_back('{kind, exp, tag});
  endtask
  task automatic expect_obs(input int kind, input logic [31:0] exp, input string tag);
    @(negedge clk); push_now(kind, exp, tag);
  endtask
  task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cpu_addr = a; push_now(K_RD, exp, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic start_tx;
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask
  task automatic finish_tx(input logic [15:0] t);
    @(negedge clk); timer = t; tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_obs(K_SEL, selx(0, 0), "R1 selection");
    expect_obs(K_BUSY, 0, "R1 busy");
    expect_obs(K_IRQ, 0, "R1 irq");
    expect_rd(A_FLAG, 0, "R1 flags");
    expect_rd(cs_a(3), 0, "R1 cs word");

    // R2 lowest identifier, tie to lower index
    wr(A_CFG, 0);
    wr(id_a(2), 32'h100); wr(id_a(5), 32'h050); wr(id_a(6), 32'h050);
    wr(cs_a(2), SEND); wr(cs_a(5), SEND); wr(cs_a(6), SEND);
    expect_obs(K_SEL, selx(1, 5), "R2 lowest id tie");

    // R3 index order
    wr(A_CFG, 1);
    expect_obs(K_SEL, selx(1, 2), "R3 index order");

    // R4 local priority above identifier
    wr(A_CFG, 2);
    wr(cs_a(2), SEND | 32'h0010_0000);
    wr(cs_a(5), SEND | 32'h0030_0000);
    wr(cs_a(6), SEND | 32'h0030_0000);
    expect_obs(K_SEL, selx(1, 2), "R4 local priority");

    // R5 inactive codes excluded
    wr(cs_a(2), INACT);
    expect_obs(K_SEL, selx(1, 5), "R5 code 1000 excluded");
    wr(cs_a(5), ABRT);
    expect_obs(K_SEL, selx(1, 6), "R5 code 1001 excluded");

    // R6 CS write removes mailbox from the same-cycle run
    wr(cs_a(6), SEND | 32'h0030_0000);
    push_now(K_SEL, selx(0, 0), "R6 excluded during write");
    expect_obs(K_SEL, selx(1, 6), "R6 back after write");

    // R7 / R8 commit and completion
    wr(A_MASK, 32'h40);
    start_tx;
    expect_obs(K_BUSY, 1, "R7 busy after start");
    expect_obs(K_SEL, selx(1, 6), "R7 holds committed");
    finish_tx(16'hABCD);
    expect_obs(K_BUSY, 0, "R8 busy released");
    expect_rd(cs_a(6), 32'h0830_ABCD, "R8 stamp and code");
    expect_rd(A_FLAG, 32'h40, "R8 flag set");
    expect_obs(K_IRQ, 1, "R8 irq raised");
    expect_obs(K_SEL, selx(0, 0), "R8 nothing left");

    // R12 write-one-to-clear
    wr(A_FLAG, 32'h40);
    expect_rd(A_FLAG, 0, "R12 flag cleared");
    expect_obs(K_IRQ, 0, "R12 irq cleared");

    // R9 abort
    wr(A_CFG, 4);
    wr(id_a(1), 32'h10); wr(id_a(3), 32'h20);
    wr(cs_a(1), SEND); wr(cs_a(3), SEND);
    expect_obs(K_SEL, selx(1, 1), "R9 setup winner");
    wr(cs_a(3), ABRT);
    expect_rd(cs_a(3), ABRT, "R9 abort code stored");
    expect_rd(A_FLAG, 32'h08, "R9 abort flag");
    start_tx;
    wr(cs_a(1), ABRT);
    expect_rd(cs_a(1), SEND, "R9 committed write ignored");
    finish_tx(16'h0077);
    expect_rd(cs_a(1), INACT | 32'h77, "R9 committed frame completes");
    expect_rd(A_FLAG, 32'h0A, "R9 flags after completion");
    expect_obs(K_IRQ, 0, "R8 masked flags give no irq");

    // R10 lock while flag set
    wr(cs_a(3), SEND);
    expect_rd(cs_a(3), ABRT, "R10 cs locked");
    wr(id_a(3), 32'h333);
    expect_rd(id_a(3), 32'h20, "R10 id locked");
    wr(A_FLAG, 32'h08);
    expect_rd(A_FLAG, 32'h02, "R10 flag cleared");
    wr(cs_a(3), SEND);
    expect_rd(cs_a(3), SEND, "R10 unlocked write");

    // R12 completion beats same-cycle clear
    expect_obs(K_SEL, selx(1, 3), "R12 setup winner");
    start_tx;
    @(negedge clk);
    timer = 16'h0100; tx_done = 1'b1;
    cpu_wr = 1'b1; cpu_addr = A_FLAG; cpu_wdata = 32'h0A;
    @(negedge clk);
    tx_done = 1'b0; cpu_wr = 1'b0;
    expect_rd(A_FLAG, 32'h08, "R12 set wins over clear");
    expect_rd(cs_a(3), INACT | 32'h100, "R12 completion applied");

    // R11 silent completion with abort disabled
    wr(A_CFG, 0);
    wr(A_FLAG, 32'h08);
    wr(id_a(4), 32'h5); wr(cs_a(4), SEND);
    expect_obs(K_SEL, selx(1, 4), "R11 setup winner");
    start_tx;
    wr(cs_a(4), INACT);
    finish_tx(16'h5555);
    expect_rd(cs_a(4), INACT, "R11 no stamp");
    expect_rd(A_FLAG, 0, "R11 no flag");
    expect_obs(K_BUSY, 0, "R11 busy released");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule